// File: doc/BRIEF.md
# Accumulator Normalization Step Unit

This block carries out a single normalization iteration on a 56-bit signed accumulator. The accumulator is split into an 8-bit extension, a 24-bit upper word and a 24-bit lower word. A start strobe hands the block three things: the accumulator, a 16-bit shift-count register, and an 8-bit condition-flag byte that describes the accumulator.

The block reads the extension-in-use, unnormalized and zero flags from the flag byte and picks one of three actions. It can shift the accumulator left by one and decrement the count. It can shift the accumulator right by one, keeping the sign, and increment the count. Or it can leave both unchanged. It then returns the new accumulator, the new count and freshly computed flags, and raises a one-cycle done strobe.

Full normalization is done by issuing the step repeatedly from outside. Each step's outputs are fed back as the next step's inputs. When the repetition ends, the count register holds the signed number of shifts: negative for left shifts, positive for right shifts.

Top module: `norm_step_unit`

## Requirements
- R1: After reset `accOut`, `cntOut` and `flagsOut` are all zero and `doneStb` is low.
- R2: If the input flags show E=0, U=1 and Z=0 (flag byte bit 3 is E, bit 2 is U, bit 0 is Z), the accumulator is shifted left by one, a zero enters bit 0, and the count is decremented by one.
- R3: Otherwise, if the input flag E is 1, the accumulator is shifted right by one with bit 55 copied into itself, and the count is incremented by one.
- R4: In every other flag combination, including a zero or normalized accumulator, the accumulator and count come out equal to the values given with the start strobe.
- R5: The count wraps modulo 2^16: a decrement of 0x0000 gives 0xFFFF, and an increment of 0xFFFF gives 0x0000.
- R6: The output flags are recomputed from the new accumulator. Bit 0 (Z) is set when all 56 bits are zero. Bit 1 (N) copies bit 55. Bit 3 (E) is set when bits 55..47 are not all equal. Bit 2 (U) is set when bit 47 equals bit 46.
- R7: Output bit 4 (V) is set only when a left shift changes bit 55, and is clear otherwise. Output bit 5 (L) is the input L ORed with the new V. Bits 6 (C) and 7 pass through unchanged.
- R8: A start sampled in cycle n gives a single-cycle `doneStb` in cycle n+2. The outputs take their new values in that same cycle and hold them at all other times.
- R9: A start strobe that arrives in the cycle right after an accepted start is ignored. The next accepted start can come two cycles after the previous one.
- R10: Starting from accumulator 0x00_000000_000001, count 0x0000 and matching flags, 46 repeated steps give accumulator 0x00_400000_000000 and count 0xFFD2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Begin one normalization step |
| accIn | input | 56 | Accumulator value before the step |
| cntIn | input | 16 | Shift-count register before the step |
| flagsIn | input | 8 | Condition flags that describe `accIn` |
| accOut | output | 56 | Accumulator after the step |
| cntOut | output | 16 | Shift-count register after the step |
| flagsOut | output | 8 | Recomputed condition flags |
| doneStb | output | 1 | One-cycle pulse when the results are valid |

## Verification
A start sampled at one rising edge is captured on that edge. The results and the done pulse appear after the following edge, so they are due two cycles after the start cycle and then stay stable until the next step. The bench's reference model keeps a queue of pending steps, each tagged with the cycle in which it retires. At every falling edge the model compares the done strobe, accumulator, count and flags against those retirement times. As a result, a result that arrives early, late, twice, or from an ignored start is seen in the exact cycle where it goes wrong.

// File: rtl/norm_step_pkg.sv
package norm_step_pkg;

  localparam int FLAG_W = 8;
  localparam int FZ = 0;
  localparam int FN = 1;
  localparam int FU = 2;
  localparam int FE = 3;
  localparam int FV = 4;
  localparam int FL = 5;

  typedef struct packed {
    logic capture;
    logic commit;
  } normCtl_t;

  typedef enum logic {ST_IDLE, ST_EXEC} normState_t;

  typedef enum logic [1:0] {OP_NOP, OP_LEFT, OP_RIGHT} normOp_t;

endpackage

// File: rtl/norm_flag_eval.sv
module norm_flag_eval #(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24,
  localparam int ACC_W = EXT_W + 2 * WORD_W
) (
  input  logic [ACC_W-1:0] val,
  output logic             isZero,
  output logic             isNeg,
  output logic             extUsed,
  output logic             unNorm
);
  localparam int SIGN_POS = 2 * WORD_W - 1;
  localparam int TOP_W    = ACC_W - SIGN_POS;

  logic [TOP_W-1:0] topBits;

  always_comb begin
    topBits = val[ACC_W-1:SIGN_POS];
    isZero  = (val == '0);
    isNeg   = val[ACC_W-1];
    extUsed = (|topBits) && !(&topBits);
    unNorm  = (val[SIGN_POS] == val[SIGN_POS-1]);
  end
endmodule

// File: rtl/norm_step_ctrl.sv
module norm_step_ctrl
  import norm_step_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     startStb,
  output normCtl_t ctl,
  output logic     doneStb
);
  normState_t state;

  always_comb begin
    ctl.capture = (state == ST_IDLE) && startStb;
    ctl.commit  = (state == ST_EXEC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      doneStb <= 1'b0;
    end else begin
      doneStb <= ctl.commit;
      case (state)
        ST_IDLE: if (startStb) state <= ST_EXEC;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneStb |=> !doneStb);

  // R8
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneStb |-> $past(startStb, 2));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && startStb) |=> !ctl.commit);
endmodule

// File: rtl/norm_step_dpath.sv
module norm_step_dpath
  import norm_step_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24,
  parameter int CNT_W  = 16,
  localparam int ACC_W = EXT_W + 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  normCtl_t          ctl,
  input  logic [ACC_W-1:0]  accIn,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [ACC_W-1:0]  accOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic [FLAG_W-1:0] flagsOut
);
  logic [ACC_W-1:0]  accQ;
  logic [CNT_W-1:0]  cntQ;
  logic [FLAG_W-1:0] flagQ;

  normOp_t           opSel;
  logic [ACC_W-1:0]  accNext;
  logic [CNT_W-1:0]  cntNext;
  logic [FLAG_W-1:0] flagNext;
  logic              vNew;
  logic              nZero, nNeg, nExt, nUnn;

  // step decision from the flags supplied with the operand
  always_comb begin
    if (!flagQ[FE] && flagQ[FU] && !flagQ[FZ]) opSel = OP_LEFT;
    else if (flagQ[FE])                         opSel = OP_RIGHT;
    else                                        opSel = OP_NOP;
  end

  always_comb begin
    accNext = accQ;
    cntNext = cntQ;
    vNew    = 1'b0;
    case (opSel)
      OP_LEFT: begin
        accNext = {accQ[ACC_W-2:0], 1'b0};
        cntNext = cntQ - CNT_W'(1);
        vNew    = accQ[ACC_W-1] ^ accQ[ACC_W-2];
      end
      OP_RIGHT: begin
        accNext = {accQ[ACC_W-1], accQ[ACC_W-1:1]};
        cntNext = cntQ + CNT_W'(1);
      end
      default: ;
    endcase
  end

  norm_flag_eval #(.EXT_W(EXT_W), .WORD_W(WORD_W)) flagEval_i (
    .val    (accNext),
    .isZero (nZero),
    .isNeg  (nNeg),
    .extUsed(nExt),
    .unNorm (nUnn)
  );

  always_comb begin
    flagNext     = flagQ;
    flagNext[FZ] = nZero;
    flagNext[FN] = nNeg;
    flagNext[FE] = nExt;
    flagNext[FU] = nUnn;
    flagNext[FV] = vNew;
    flagNext[FL] = flagQ[FL] | vNew;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accQ     <= '0;
      cntQ     <= '0;
      flagQ    <= '0;
      accOut   <= '0;
      cntOut   <= '0;
      flagsOut <= '0;
    end else begin
      if (ctl.capture) begin
        accQ  <= accIn;
        cntQ  <= cntIn;
        flagQ <= flagsIn;
      end
      if (ctl.commit) begin
        accOut   <= accNext;
        cntOut   <= cntNext;
        flagsOut <= flagNext;
      end
    end
  end

  // R2
  left_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.commit && opSel == OP_LEFT) |=> cntOut == $past(cntQ) - CNT_W'(1));

  // R3
  right_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.commit && opSel == OP_RIGHT) |=> accOut[ACC_W-1] == $past(accQ[ACC_W-1]));

  // R4
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.commit && opSel == OP_NOP) |=> (accOut == $past(accQ)) && (cntOut == $past(cntQ)));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.commit |=> flagsOut[FZ] == (accOut == '0));

  // R7
  sticky_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.commit && flagQ[FL]) |=> flagsOut[FL]);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.commit |=> $stable(accOut) && $stable(cntOut) && $stable(flagsOut));
endmodule

// File: rtl/norm_step_unit.sv
module norm_step_unit
  import norm_step_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24,
  parameter int CNT_W  = 16,
  localparam int ACC_W = EXT_W + 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startStb,
  input  logic [ACC_W-1:0]  accIn,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [ACC_W-1:0]  accOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              doneStb
);
  normCtl_t ctl;

  norm_step_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .startStb(startStb),
    .ctl     (ctl),
    .doneStb (doneStb)
  );

  norm_step_dpath #(.EXT_W(EXT_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) dpath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .accIn   (accIn),
    .cntIn   (cntIn),
    .flagsIn (flagsIn),
    .accOut  (accOut),
    .cntOut  (cntOut),
    .flagsOut(flagsOut)
  );
endmodule

// File: tb/norm_step_unit_tb.sv
module norm_step_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startStb = 1'b0;
  logic [55:0] accIn = '0;
  logic [15:0] cntIn = '0;
  logic [7:0]  flagsIn = '0;
  logic [55:0] accOut;
  logic [15:0] cntOut;
  logic [7:0]  flagsOut;
  logic        doneStb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  norm_step_unit dut_i (
    .clk(clk), .rst_n(rst_n), .startStb(startStb),
    .accIn(accIn), .cntIn(cntIn), .flagsIn(flagsIn),
    .accOut(accOut), .cntOut(cntOut), .flagsOut(flagsOut), .doneStb(doneStb)
  );

  typedef struct {
    int          due;
    logic [55:0] acc;
    logic [15:0] cnt;
    logic [7:0]  flg;
  } pend_t;

  pend_t       pendQ[$];
  int          lastAccept = -10;
  logic [55:0] expAcc = '0;
  logic [15:0] expCnt = '0;
  logic [7:0]  expFlg = '0;
  logic        expDone = 1'b0;
  string       expTag = "R1";

  function automatic logic [7:0] mkFlags(logic [55:0] a, logic lBit, logic cBit);
    logic [7:0] f;
    f = '0;
    f[0] = (a == 56'd0);
    f[1] = a[55];
    f[3] = (a[55:47] != 9'h000) && (a[55:47] != 9'h1FF);
    f[2] = (a[47] == a[46]);
    f[5] = lBit;
    f[6] = cBit;
    return f;
  endfunction

  task automatic refStep(input logic [55:0] a, input logic [15:0] c, input logic [7:0] f,
                         output logic [55:0] na, output logic [15:0] nc,
                         output logic [7:0] nf, output string tag);
    logic v;
    v = 1'b0;
    na = a;
    nc = c;
    tag = "R4";
    if (!f[3] && f[2] && !f[0]) begin
      na = a << 1;
      nc = 16'((int'(c) + 65535) % 65536);
      v = (a[55] != na[55]);
      tag = "R2";
    end else if (f[3]) begin
      na = $unsigned($signed(a) >>> 1);
      nc = 16'((int'(c) + 1) % 65536);
      tag = "R3";
    end
    nf = mkFlags(na, f[5] | v, f[6]);
    nf[4] = v;
    nf[7] = f[7];
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model: accepts starts, retires each one on its due cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      pendQ.delete();
      expAcc <= '0; expCnt <= '0; expFlg <= '0; expDone <= 1'b0;
      lastAccept = -10;
    end else begin
      pend_t p;
      expDone <= 1'b0;
      if (pendQ.size() > 0 && pendQ[0].due == cyc) begin
        logic [55:0] na; logic [15:0] nc; logic [7:0] nf; string tg;
        p = pendQ.pop_front();
        refStep(p.acc, p.cnt, p.flg, na, nc, nf, tg);
        expAcc <= na; expCnt <= nc; expFlg <= nf; expDone <= 1'b1; expTag = tg;
      end
      if (startStb && (cyc != lastAccept + 1)) begin
        p.due = cyc + 1; p.acc = accIn; p.cnt = cntIn; p.flg = flagsIn;
        pendQ.push_back(p);
        lastAccept = cyc;
      end
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n && cyc > 2) begin
      chk(doneStb == expDone, "R8 done", 64'(doneStb), 64'(expDone));
      chk(accOut == expAcc, {expTag, " acc"}, 64'(accOut), 64'(expAcc));
      chk(cntOut == expCnt, {expTag, " cnt"}, 64'(cntOut), 64'(expCnt));
      chk(flagsOut == expFlg, "R6/R7 flags", 64'(flagsOut), 64'(expFlg));
    end
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic issue(input logic [55:0] a, input logic [15:0] c, input logic [7:0] f);
    @(negedge clk);
    startStb = 1'b1; accIn = a; cntIn = c; flagsIn = f;
    @(negedge clk);
    startStb = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [55:0] ea; logic [15:0] ec; logic [7:0] ef; string tg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(accOut == 0 && cntOut == 0 && flagsOut == 0 && !doneStb, "R1 reset",
        64'(accOut), 64'd0);

    // R2 positive left shift with count wrap (R5)
    issue(56'h00_000000_000003, 16'h0000, mkFlags(56'h00_000000_000003, 0, 0));
    chk(accOut == 56'h00_000000_000006, "R2 left", 64'(accOut), 64'h6);
    chk(cntOut == 16'hFFFF, "R5 wrap down", 64'(cntOut), 64'hFFFF);

    // R2 negative left shift
    issue(56'hFF_C00000_000001, 16'h0010, mkFlags(56'hFF_C00000_000001, 0, 0));
    chk(accOut == 56'hFF_800000_000002, "R2 neg left", 64'(accOut), 64'hFF800000000002);
    chk(cntOut == 16'h000F, "R2 count", 64'(cntOut), 64'hF);

    // R3 negative right shift, sign kept, count wrap up (R5)
    issue(56'h80_000000_000002, 16'hFFFF, mkFlags(56'h80_000000_000002, 0, 1));
    chk(accOut == 56'hC0_000000_000001, "R3 right", 64'(accOut), 64'hC0000000000001);
    chk(cntOut == 16'h0000, "R5 wrap up", 64'(cntOut), 64'h0);
    chk(flagsOut[6] == 1'b1, "R7 carry passes", 64'(flagsOut), 64'h40);

    // R4 zero and normalized values untouched
    issue(56'h0, 16'h1234, mkFlags(56'h0, 0, 0));
    chk(accOut == 56'h0 && cntOut == 16'h1234, "R4 zero", 64'(cntOut), 64'h1234);
    issue(56'h00_400000_000000, 16'h0042, mkFlags(56'h00_400000_000000, 0, 0));
    chk(accOut == 56'h00_400000_000000 && cntOut == 16'h0042, "R4 normalized",
        64'(accOut), 64'h00400000000000);

    // R7 improper flags force a left shift that flips bit 55
    issue(56'h40_000000_000000, 16'h0005, 8'h04);
    chk(flagsOut[4] && flagsOut[5], "R7 V and L set", 64'(flagsOut), 64'h30);
    // R7 sticky L survives a no-op
    issue(56'h00_400000_000000, 16'h0000, mkFlags(56'h00_400000_000000, 1, 0));
    chk(flagsOut[5] && !flagsOut[4], "R7 L sticky", 64'(flagsOut), 64'h20);

    // R9 back-to-back start: second is ignored
    @(negedge clk);
    startStb = 1'b1; accIn = 56'h00_000000_000010; cntIn = 16'h0; flagsIn = mkFlags(56'h10, 0, 0);
    @(negedge clk);
    accIn = 56'h7F_000000_000000; cntIn = 16'h0100; flagsIn = mkFlags(56'h7F_000000_000000, 0, 0);
    @(negedge clk);
    startStb = 1'b0;
    @(negedge clk);
    refStep(56'h00_000000_000010, 16'h0, mkFlags(56'h10, 0, 0), ea, ec, ef, tg);
    chk(accOut == ea && cntOut == ec, "R9 ignored start", 64'(accOut), 64'(ea));
    @(negedge clk);
    chk(!doneStb, "R9 no second done", 64'(doneStb), 64'd0);

    // R10 repeated normalization from 1
    issue(56'h00_000000_000001, 16'h0000, mkFlags(56'h1, 0, 0));
    for (int i = 1; i < 46; i++) issue(accOut, cntOut, flagsOut);
    chk(accOut == 56'h00_400000_000000, "R10 acc", 64'(accOut), 64'h00400000000000);
    chk(cntOut == 16'hFFD2, "R10 count", 64'(cntOut), 64'hFFD2);
    issue(accOut, cntOut, flagsOut);
    chk(cntOut == 16'hFFD2, "R10 settled", 64'(cntOut), 64'hFFD2);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule